// File: doc/BRIEF.md
# Filtered Interrupt Request Collector

This block gathers up to sixteen interrupt request lines into one interrupt output for a processor. The low-numbered lines come from external pins, each passing through a clock-counted glitch filter. A selectable trigger detector follows the filter and can fire on a rising edge, a falling edge, a high level or a low level. The remaining lines come from on-chip peripherals and are caught on their rising edge.

Each source owns a pending flag and an enable bit. The processor reads the pending flags and clears them by writing ones. It sets the enable mask, the trigger types and the filter lengths through a small register port. Writes take effect at the clock edge, and reads return data combinationally from the address. The interrupt output is the OR of every pending flag whose enable bit is set.

Top module: `irq_filter_ctrl`

## Requirements
- R1: After reset the enable mask, the pending flags, the trigger and filter fields are all zero, and `irq` is low.
- R2: Internal line j sets pending bit NUM_EXT+j on its rising edge. The flag stays set after the line falls, until it is cleared.
- R3: External pin i updates its filtered value only after the pin has differed from that value for K consecutive clocks, where K = F*FILT_UNIT. F is the 4-bit filter field at bits [4i+3:4i] of address 3, and F=0 means K=1. A shorter pulse is ignored. With a rising trigger, the pending bit is readable one clock after the filtered value changes, that is K+1 edges after the pin changes.
- R4: The trigger field of pin i sits at bits [2i+1:2i] of address 2. The codes are 00 rising edge, 01 falling edge, 10 high level and 11 low level. An external source's pending flag is bit i.
- R5: In a level mode the pending flag is set again on every clock while the filtered level is active, so a clear does not stick until the level goes away.
- R6: Writing address 1 clears each pending bit whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R7: If a source's set condition and its clear arrive in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when some pending bit has its enable bit set. A pending but disabled source is still visible in the pending flags.
- R9: The register map is as follows. Address 0 holds the enable mask (read/write). Address 1 reads the pending flags. Address 2 holds the trigger fields and address 3 the filter fields. Address 4 reads pending AND enable. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | NUM_EXT | External request pins |
| int_irq | input | NUM_SRC-NUM_EXT | On-chip request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for reg_addr |
| irq | output | 1 | Combined interrupt to the processor |

## Verification
A new rising edge on a source and a software clear of that same source can land in the same clock. The bench first latches a flag on an internal line and then drops the line. In one cycle it raises the line again and writes a one to that bit of the clear register. It judges the result by reading the flag back as still set, and then shows that a lone clear does remove it. A second overlap arises between a clear and a persisting level in level mode: the flag must read set again right after the clear.

// File: rtl/irq_filter_ctrl.sv
module irq_filter_ctrl #(
  parameter int NUM_SRC   = 16,
  parameter int NUM_EXT   = 4,
  parameter int FILT_UNIT = 4,
  parameter int AW        = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_EXT-1:0]         ext_irq,
  input  logic [NUM_SRC-NUM_EXT-1:0] int_irq,
  input  logic                       reg_wr,
  input  logic [AW-1:0]              reg_addr,
  input  logic [NUM_SRC-1:0]         reg_wdata,
  output logic [NUM_SRC-1:0]         reg_rdata,
  output logic                       irq
);
  localparam int NI = NUM_SRC - NUM_EXT;
  localparam int CW = $clog2(15 * FILT_UNIT + 2);

  logic [NUM_SRC-1:0]   en, pend, set_vec, clr_vec;
  logic [2*NUM_EXT-1:0] trig;
  logic [4*NUM_EXT-1:0] fsel;
  logic [NUM_EXT-1:0]   filt, fprev;
  logic [NI-1:0]        int_prev;

  assign clr_vec = (reg_wr && reg_addr == AW'(1)) ? reg_wdata : '0;
  assign set_vec[NUM_SRC-1:NUM_EXT] = int_irq & ~int_prev;
  assign irq = |(pend & en);

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    logic [CW-1:0] cnt, lim;
    logic          fq;
    assign lim = (fsel[4*i+:4] == 4'd0) ? CW'(1) : CW'(fsel[4*i+:4]) * CW'(FILT_UNIT);
    assign filt[i] = fq;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        fq  <= 1'b0;
      end else if (ext_irq[i] == fq) begin
        cnt <= '0;
      end else if (cnt + CW'(1) >= lim) begin
        cnt <= '0;
        fq  <= ext_irq[i];
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
    always_comb begin
      case (trig[2*i+:2])
        2'b00:   set_vec[i] = fq & ~fprev[i];
        2'b01:   set_vec[i] = ~fq & fprev[i];
        2'b10:   set_vec[i] = fq;
        default: set_vec[i] = ~fq;
      endcase
    end

    a_r3_filter_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (fq != $past(fq)) |-> (fq == $past(ext_irq[i])));
    a_r5_high_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[2*i+:2] == 2'b10 && fq) |=> pend[i]);
    a_r5_low_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[2*i+:2] == 2'b11 && !fq) |=> pend[i]);
  end

  for (genvar j = 0; j < NI; j++) begin : g_int
    a_r6_only_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[NUM_EXT+j]) |-> $past(clr_vec[NUM_EXT+j]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= '0;
      pend     <= '0;
      trig     <= '0;
      fsel     <= '0;
      fprev    <= '0;
      int_prev <= '0;
    end else begin
      fprev    <= filt;
      int_prev <= int_irq;
      pend     <= (pend & ~clr_vec) | set_vec;
      if (reg_wr) begin
        case (reg_addr)
          AW'(0): en   <= reg_wdata;
          AW'(2): trig <= reg_wdata[2*NUM_EXT-1:0];
          AW'(3): fsel <= reg_wdata[4*NUM_EXT-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(0): reg_rdata = en;
      AW'(1): reg_rdata = pend;
      AW'(2): reg_rdata[2*NUM_EXT-1:0] = trig;
      AW'(3): reg_rdata[4*NUM_EXT-1:0] = fsel;
      AW'(4): reg_rdata = pend & en;
      default: ;
    endcase
  end

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend & $past(set_vec)) == $past(set_vec)));
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

// File: tb/irq_filter_ctrl_tb.sv
module irq_filter_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ext_irq = '0;
  logic [11:0] int_irq = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;

  irq_filter_ctrl u_dut (.clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .int_irq(int_irq),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(0, v); chk("R1 enable", v, 16'h0);
    rd(1, v); chk("R1 pending", v, 16'h0);
    rd(2, v); chk("R1 trigger", v, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_internal_edge;
    logic [15:0] v;
    int_irq[0] = 1'b1; cyc(1);
    rd(1, v); chk("R2 set on rise", v, 16'h0010);
    int_irq[0] = 1'b0; cyc(3);
    rd(1, v); chk("R2 latched", v, 16'h0010);
  endtask

  task automatic t_w1c;
    logic [15:0] v;
    int_irq[1] = 1'b1; cyc(1); int_irq[1] = 1'b0;
    wr(1, 16'h0000);
    rd(1, v); chk("R6 zero write no effect", v, 16'h0030);
    wr(1, 16'h0010);
    rd(1, v); chk("R6 one clears bit", v, 16'h0020);
    wr(1, 16'h0020);
    rd(1, v); chk("R6 all cleared", v, 16'h0000);
  endtask

  task automatic t_enable_mask;
    logic [15:0] v;
    wr(0, 16'h0010);
    int_irq[2] = 1'b1; cyc(1); int_irq[2] = 1'b0;
    chk("R8 disabled pending quiet", {15'd0, irq}, 16'h0);
    rd(1, v); chk("R8 pending visible", v, 16'h0040);
    rd(4, v); chk("R9 status masked", v, 16'h0000);
    int_irq[0] = 1'b1; cyc(1); int_irq[0] = 1'b0;
    chk("R8 enabled raises irq", {15'd0, irq}, 16'h1);
    rd(4, v); chk("R9 status", v, 16'h0010);
    rd(0, v); chk("R9 enable readback", v, 16'h0010);
    rd(6, v); chk("R9 unused reads zero", v, 16'h0000);
    wr(1, 16'h0050);
    chk("R8 irq drops after clear", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_filter;
    logic [15:0] v;
    wr(3, 16'h0002);
    rd(3, v); chk("R9 filter readback", v, 16'h0002);
    ext_irq[0] = 1'b1; cyc(7); ext_irq[0] = 1'b0; cyc(10);
    rd(1, v); chk("R3 glitch ignored", v, 16'h0000);
    ext_irq[0] = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk); rd(1, v); chk("R3 not before K+1 edges", v, 16'h0000);
    @(negedge clk); rd(1, v); chk("R3 accepted after K", v, 16'h0001);
    ext_irq[0] = 1'b0; cyc(12);
    rd(1, v); chk("R4 rising edge latched", v, 16'h0001);
    wr(1, 16'h0001);
  endtask

  task automatic t_falling;
    logic [15:0] v;
    wr(2, 16'h0004);
    ext_irq[1] = 1'b1; cyc(3);
    rd(1, v); chk("R4 falling ignores rise", v, 16'h0000);
    ext_irq[1] = 1'b0; cyc(2);
    rd(1, v); chk("R4 falling sets", v, 16'h0002);
    wr(1, 16'h0002);
  endtask

  task automatic t_levels;
    logic [15:0] v;
    ext_irq[3] = 1'b1;
    wr(2, 16'h00E4);
    cyc(3); wr(1, 16'h000F);
    rd(1, v); chk("R5 idle levels clear", v, 16'h0000);
    ext_irq[2] = 1'b1; cyc(3);
    rd(1, v); chk("R4 high level sets", v, 16'h0004);
    wr(1, 16'h0004);
    rd(1, v); chk("R5 high level reasserts", v, 16'h0004);
    ext_irq[2] = 1'b0; cyc(3); wr(1, 16'h0004);
    rd(1, v); chk("R5 high gone clears", v, 16'h0000);
    ext_irq[3] = 1'b0; cyc(3);
    rd(1, v); chk("R4 low level sets", v, 16'h0008);
    wr(1, 16'h0008);
    rd(1, v); chk("R5 low level reasserts", v, 16'h0008);
    ext_irq[3] = 1'b1; cyc(3); wr(1, 16'h0008);
    rd(1, v); chk("R5 low gone clears", v, 16'h0000);
  endtask

  task automatic t_collision;
    logic [15:0] v;
    int_irq[3] = 1'b1; cyc(1); int_irq[3] = 1'b0; cyc(1);
    rd(1, v); chk("R7 armed", v, 16'h0080);
    int_irq[3] = 1'b1;
    wr(1, 16'h0080);
    rd(1, v); chk("R7 edge wins over clear", v, 16'h0080);
    wr(1, 16'h0080);
    rd(1, v); chk("R7 lone clear works", v, 16'h0000);
    int_irq[3] = 1'b0;
  endtask

  initial begin
    fork
      begin
        cyc(3); rst_n = 1'b1; cyc(1);
        t_reset(); t_internal_edge(); t_w1c(); t_enable_mask();
        t_filter(); t_falling(); t_levels(); t_collision();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule